// File: doc/BRIEF.md
# Hysteresis Threshold Slicer

This block turns a stream of 6-bit unsigned line-voltage codes into a single registered line level. Each code arrives with a valid strobe from an upstream converter. The block compares each valid code against two thresholds. The lower threshold is a programmable base code. The upper threshold is the base code plus an offset picked from four fixed choices, and the sum saturates at the top code.

Between the two thresholds the level holds its previous value. This gives noise immunity when the line sits near the decision point. A one-cycle change flag marks every toggle of the level, so a downstream bit decoder can time transitions without keeping its own copy of the level.

Settings come in through a single-word write port that carries the base code and the hysteresis select together. A write becomes visible only to valid samples after the write cycle. A sample never sees half-updated thresholds.

Top module: `slicer_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `level` is 0 and `level_chg` is 0 until the first valid sample that changes the level.
- R2: With hysteresis select 0, the upper threshold equals the base code.
- R3: With hysteresis select 1, the upper threshold is the base code plus 5.
- R4: With hysteresis select 2, the upper threshold is the base code plus 10.
- R5: With hysteresis select 3, the upper threshold is the base code plus 32.
- R6: When base plus offset exceeds 63, the upper threshold is 63, so no sample can drive `level` high.
- R7: On a valid sample, `level` becomes 1 if the sample is strictly above the upper threshold. It becomes 0 if the sample is at or below the base code. Otherwise it keeps its value. The new level appears one clock after the sample edge.
- R8: A cycle without `sample_valid` leaves `level` unchanged, whatever `sample` carries.
- R9: A write applies only to valid samples in later cycles. A valid sample in the same cycle as a write is judged against the settings in force before the write.
- R10: `level_chg` is high for exactly the one cycle in which `level` shows a new value, and is low otherwise.
- R11: The write word carries the base code in bits [5:0] and the hysteresis select in bits [7:6]. After reset the settings are base 0 and select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the settings word |
| cfg_wdata | input | 8 | Settings word: [5:0] base code, [7:6] hysteresis select |
| sample_valid | input | 1 | Qualifies `sample` this cycle |
| sample | input | 6 | Unsigned line-voltage code |
| level | output | 1 | Registered sliced line level |
| level_chg | output | 1 | One-cycle pulse when `level` changes |

## Verification
A settings write and a valid sample can land in the same cycle. The design must then judge the sample against the old thresholds and apply the new ones from the next sample onward. The bench provokes this directly: while the level is high, it writes a base code above the sample and strobes that sample in the same cycle. The level must stay high. The next valid sample of the same code must pull it low. The random phase also mixes writes and samples freely, and a bench model keeps the settings in force before each write.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  typedef enum logic [1:0] {
    HYS_NONE  = 2'd0,
    HYS_SMALL = 2'd1,
    HYS_MED   = 2'd2,
    HYS_LARGE = 2'd3
  } hys_sel_e;
endpackage

// File: rtl/slicer_cfg_regs.sv
module slicer_cfg_regs
  import slicer_pkg::*;
#(
  parameter int CODE_W = 6,
  localparam int WORD_W = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [CODE_W-1:0] base_q,
  output hys_sel_e          hys_q
);
  logic [CODE_W-1:0] base_d;
  hys_sel_e          hys_d;

  always_comb begin
    base_d = base_q;
    hys_d  = hys_q;
    if (we) begin
      base_d = wdata[CODE_W-1:0];
      hys_d  = hys_sel_e'(wdata[WORD_W-1:CODE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      hys_q  <= HYS_NONE;
    end else if (we) begin
      base_q <= base_d;
      hys_q  <= hys_d;
    end
  end
endmodule

// File: rtl/slicer_thresh.sv
module slicer_thresh
  import slicer_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int OFS_SMALL = 5,
  parameter int OFS_MED   = 10,
  parameter int OFS_LARGE = 32,
  localparam int SUM_W   = CODE_W + 1
) (
  input  logic [CODE_W-1:0] base,
  input  hys_sel_e          hys,
  output logic [CODE_W-1:0] upper
);
  localparam logic [SUM_W-1:0] MAX_CODE = SUM_W'((1 << CODE_W) - 1);

  logic [SUM_W-1:0] offset;
  logic [SUM_W-1:0] sum;

  always_comb begin
    unique case (hys)
      HYS_SMALL: offset = SUM_W'(OFS_SMALL);
      HYS_MED:   offset = SUM_W'(OFS_MED);
      HYS_LARGE: offset = SUM_W'(OFS_LARGE);
      default:   offset = '0;
    endcase
    sum = {1'b0, base} + offset;
    if (sum > MAX_CODE) upper = MAX_CODE[CODE_W-1:0];
    else                upper = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/slicer_decide.sv
module slicer_decide #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CODE_W-1:0] sample,
  input  logic [CODE_W-1:0] lower,
  input  logic [CODE_W-1:0] upper,
  output logic              level_q,
  output logic              chg_q
);
  logic level_d;
  logic chg_d;

  always_comb begin
    level_d = level_q;
    if (sample > upper)       level_d = 1'b1;
    else if (sample <= lower) level_d = 1'b0;
    chg_d = valid && (level_d != level_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else if (valid) level_q <= level_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_d;
  end
endmodule

// File: rtl/slicer_top.sv
module slicer_top
  import slicer_pkg::*;
#(
  parameter int CODE_W = 6,
  localparam int WORD_W = CODE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] sample,
  output logic              level,
  output logic              level_chg
);
  logic [CODE_W-1:0] base_q;
  hys_sel_e          hys_q;
  logic [CODE_W-1:0] upper_thr;

  slicer_cfg_regs #(.CODE_W(CODE_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .base_q (base_q),
    .hys_q  (hys_q)
  );

  slicer_thresh #(.CODE_W(CODE_W)) u_thr (
    .base  (base_q),
    .hys   (hys_q),
    .upper (upper_thr)
  );

  slicer_decide #(.CODE_W(CODE_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (sample_valid),
    .sample  (sample),
    .lower   (base_q),
    .upper   (upper_thr),
    .level_q (level),
    .chg_q   (level_chg)
  );
endmodule

// File: rtl/slicer_chk.sv
module slicer_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic [CODE_W-1:0] sample,
  input logic              level,
  input logic              level_chg,
  input logic [CODE_W-1:0] base_q,
  input logic [CODE_W-1:0] upper_thr
);
  p_chg_on_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> level_chg);

  p_chg_only_on_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    level_chg |-> (level != $past(level)));

  p_hold_without_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(level));

  p_rise_above_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sample > upper_thr) |=> level);

  p_fall_at_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sample <= base_q) |=> !level);

  p_upper_not_below_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upper_thr >= base_q);
endmodule

bind slicer_top slicer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_valid (sample_valid),
  .sample       (sample),
  .level        (level),
  .level_chg    (level_chg),
  .base_q       (base_q),
  .upper_thr    (upper_thr)
);

// File: tb/sim_slicer_top.sv
`timescale 1ns/1ps
module sim_slicer_top;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       sample_valid;
  logic [5:0] sample;
  logic       level;
  logic       level_chg;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [5:0] m_base;
  logic [1:0] m_hys;
  logic       m_level;
  logic       m_chg;

  slicer_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .sample_valid (sample_valid),
    .sample       (sample),
    .level        (level),
    .level_chg    (level_chg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int upper_of(input logic [5:0] b, input logic [1:0] h);
    int u;
    case (h)
      2'd1:    u = int'(b) + 5;
      2'd2:    u = int'(b) + 10;
      2'd3:    u = int'(b) + 32;
      default: u = int'(b);
    endcase
    if (u > 63) u = 63;
    return u;
  endfunction

  function automatic logic next_level(input logic cur, input logic [5:0] s,
                                      input logic [5:0] b, input logic [1:0] h);
    if (int'(s) > upper_of(b, h)) return 1'b1;
    if (s <= b) return 1'b0;
    return cur;
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [5:0] s, input logic we,
                      input logic [7:0] wd, input string tag);
    logic prev;
    @(negedge clk);
    sample_valid = v;
    sample       = s;
    cfg_we       = we;
    cfg_wdata    = wd;
    @(posedge clk);
    prev = m_level;
    if (v) m_level = next_level(m_level, s, m_base, m_hys);
    m_chg = v && (m_level != prev);
    if (we) begin
      m_base = wd[5:0];
      m_hys  = wd[7:6];
    end
    #1;
    check(level, m_level, {tag, " level"});
    check(level_chg, m_chg, {"R10 ", tag, " level_chg"});
  endtask

  task automatic cfg(input logic [1:0] h, input logic [5:0] b);
    step(1'b0, 6'd0, 1'b1, {h, b}, "R11 write");
  endtask

  task automatic band_test(input logic [1:0] h, input int ofs, input string tag);
    cfg(h, 6'd20);
    step(1'b1, 6'd0, 1'b0, 8'd0, {tag, " start low"});
    step(1'b1, 6'(20 + ofs), 1'b0, 8'd0, {tag, " at upper stays low"});
    step(1'b1, 6'(21 + ofs), 1'b0, 8'd0, {tag, " above upper rises"});
    step(1'b1, 6'd21, 1'b0, 8'd0, {tag, " R7 in band holds"});
    step(1'b1, 6'd20, 1'b0, 8'd0, {tag, " R7 at base falls"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0; sample_valid = 1'b0; sample = '0;
    m_base = '0; m_hys = '0; m_level = 1'b0; m_chg = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(level, 1'b0, "R1 level in reset");
    check(level_chg, 1'b0, "R1 level_chg in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(level, 1'b0, "R1 level after release");
    check(level_chg, 1'b0, "R1 level_chg after release");

    // R11 reset settings: base 0, select 0 -> sample 1 rises, sample 0 falls
    step(1'b1, 6'd1, 1'b0, 8'd0, "R11 reset settings rise");
    step(1'b1, 6'd0, 1'b0, 8'd0, "R11 reset settings fall");

    // R8 samples without valid are ignored
    step(1'b0, 6'd63, 1'b0, 8'd0, "R8 ignored high sample");
    step(1'b0, 6'd63, 1'b0, 8'd0, "R8 ignored high sample again");

    band_test(2'd0, 0,  "R2");
    band_test(2'd1, 5,  "R3");
    band_test(2'd2, 10, "R4");
    band_test(2'd3, 32, "R5");

    // R6 saturation
    cfg(2'd3, 6'd60);
    step(1'b1, 6'd63, 1'b0, 8'd0, "R6 base60 sel3 max sample stays low");
    cfg(2'd1, 6'd58);
    step(1'b1, 6'd63, 1'b0, 8'd0, "R6 base58 sel1 max sample stays low");
    cfg(2'd2, 6'd53);
    step(1'b1, 6'd63, 1'b0, 8'd0, "R6 base53 sel2 exact 63 stays low");
    cfg(2'd2, 6'd52);
    step(1'b1, 6'd63, 1'b0, 8'd0, "R6 base52 sel2 upper 62 rises");

    // R9 write and sample in the same cycle
    cfg(2'd0, 6'd20);
    step(1'b1, 6'd30, 1'b0, 8'd0, "R9 setup high");
    step(1'b1, 6'd30, 1'b1, {2'd0, 6'd40}, "R9 same-cycle write uses old base");
    step(1'b1, 6'd30, 1'b0, 8'd0, "R9 next sample uses new base");
    step(1'b0, 6'd63, 1'b1, {2'd0, 6'd10}, "R9 R8 write without valid");
    step(1'b1, 6'd11, 1'b0, 8'd0, "R9 written base applies");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic v, we;
      v  = ($urandom % 10) < 7;
      we = ($urandom % 10) == 0;
      step(v, 6'($urandom), we, 8'($urandom), "R7 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule